// File: doc/BRIEF.md
# Sliced Sixteen-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit made from identical one-bit slices. Each slice takes one bit of each operand. Either operand can be complemented before use, and each operand has its own control for this. A two-bit operation code then picks one of four functions of the conditioned bits: AND, OR, the full-adder sum, or XOR. The carry travels as a ripple chain from the least significant slice to the most significant one.

Complementing operand B also sets the carry into bit 0. Because of this, selecting the adder with B complemented gives the two's-complement difference A − B. Complementing both operands of an AND or OR gives NOR or NAND. The block reports the result together with a carry flag, a signed-overflow flag and a zero flag. There are no registers inside, so the outputs follow the inputs within the same time step.

Top module: `alu16_sliced`

## Requirements
- R1: When `op` is 2'b00, `result` is the bitwise AND of the conditioned operands A' and B'. A' is `~opa` if `inv_a` is 1, otherwise `opa`. B' is `~opb` if `inv_b` is 1, otherwise `opb`.
- R2: When `op` is 2'b01, `result` is the bitwise OR of A' and B'.
- R3: When `op` is 2'b11, `result` is the bitwise XOR of A' and B'.
- R4: When `op` is 2'b10, {`carry`, `result`} equals the 17-bit sum A' + B' + `inv_b`.
- R5: `inv_a` and `inv_b` act independently. Each complements only its own operand, and this happens before the function is selected.
- R6: With `op` = 2'b10, `inv_b` = 1 and `inv_a` = 0, `result` is (A − B) mod 2^16. `carry` is 1 exactly when A ≥ B taken as unsigned values.
- R7: `overflow` is 1 exactly when the sum A' + B' + `inv_b` overflows as a signed 16-bit value. This is the case when the carry into bit 15 differs from the carry out of bit 15.
- R8: `zero` is 1 exactly when all 16 bits of `result` are 0.
- R9: `carry` and `overflow` come from the adder chain whatever the value of `op`. The logic functions ignore the carry, so the carry has no effect on `result` for those functions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| inv_a | input | 1 | Complement operand A before use |
| inv_b | input | 1 | Complement operand B before use; also the carry into bit 0 |
| op | input | 2 | Function select: 00 AND, 01 OR, 10 sum, 11 XOR |
| result | output | 16 | Selected function result |
| carry | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Signed overflow of the adder chain |
| zero | output | 1 | Result is all zeros |

## Verification
The checker re-evaluates every input change against the port-level relations for each function. These relations are: the bitwise identities with no complementing, NAND through double complementing, the unsigned sum and difference widths, signed overflow for plain addition, and the zero flag when equal operands are XORed. Other behaviour only shows up through the bench's scenarios. This covers carry and overflow while a logic function is selected, the corner operands 0000, FFFF, 8000 and 7FFF in every combination of function and complement controls, and the unsigned ordering meaning of the carry after a subtraction. It also shows that a repeated input vector gives the same outputs after unrelated traffic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_SUM = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic res;
        logic cout;
    } slice_out_t;

    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic logic parity3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

endpackage

// File: rtl/alu_cond_mux.sv
module alu_cond_mux (
    input  logic bit_in,
    input  logic invert,
    output logic bit_out
);
    always_comb begin
        if (invert) bit_out = ~bit_in;
        else        bit_out = bit_in;
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    inv_a,
    input  logic    inv_b,
    input  logic    cin,
    input  alu_op_e op,
    output slice_out_t so
);
    logic a_c, b_c;
    logic sum_bit;

    alu_cond_mux u_mux_a (.bit_in(a), .invert(inv_a), .bit_out(a_c));
    alu_cond_mux u_mux_b (.bit_in(b), .invert(inv_b), .bit_out(b_c));

    always_comb begin
        sum_bit = parity3(a_c, b_c, cin);
        so.cout = majority3(a_c, b_c, cin);
        unique case (op)
            OP_AND:  so.res = a_c & b_c;
            OP_OR:   so.res = a_c | b_c;
            OP_SUM:  so.res = sum_bit;
            OP_XOR:  so.res = a_c ^ b_c;
            default: so.res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] res,
    input  logic             c_into_msb,
    input  logic             c_out_msb,
    output logic             ovf,
    output logic             is_zero
);
    always_comb begin
        ovf     = c_into_msb ^ c_out_msb;
        is_zero = (res == '0);
    end
endmodule

// File: rtl/alu16_sliced.sv
module alu16_sliced
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry,
    output logic             overflow,
    output logic             zero
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;
    slice_out_t     slice_q [WIDTH];
    alu_op_e        op_sel;

    assign op_sel   = alu_op_e'(op);
    assign chain[0] = inv_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .a     (opa[i]),
            .b     (opb[i]),
            .inv_a (inv_a),
            .inv_b (inv_b),
            .cin   (chain[i]),
            .op    (op_sel),
            .so    (slice_q[i])
        );
        assign result[i]  = slice_q[i].res;
        assign chain[i+1] = slice_q[i].cout;
    end

    assign carry = chain[WIDTH];

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res        (result),
        .c_into_msb (chain[MSB]),
        .c_out_msb  (chain[WIDTH]),
        .ovf        (overflow),
        .is_zero    (zero)
    );
endmodule

// File: rtl/alu16_sliced_chk.sv
module alu16_sliced_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             inv_a,
    input logic             inv_b,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             carry,
    input logic             overflow,
    input logic             zero
);
    logic [WIDTH:0] plain_sum;
    logic [WIDTH:0] diff_sum;

    always_comb begin
        plain_sum = {1'b0, opa} + {1'b0, opb};
        diff_sum  = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, 1'b1};
        if (op == 2'b00 && !inv_a && !inv_b)
            AST_AND_BITWISE: assert (result == (opa & opb)) else $error("AND mismatch"); // R1
        if (op == 2'b01 && !inv_a && !inv_b)
            AST_OR_BITWISE: assert (result == (opa | opb)) else $error("OR mismatch"); // R2
        if (op == 2'b11 && !inv_a && !inv_b)
            AST_XOR_BITWISE: assert (result == (opa ^ opb)) else $error("XOR mismatch"); // R3
        if (op == 2'b10 && !inv_a && !inv_b)
            AST_PLAIN_SUM: assert ({carry, result} == plain_sum) else $error("sum mismatch"); // R4
        if (op == 2'b01 && inv_a && inv_b)
            AST_NAND_BY_INV: assert (result == ~(opa & opb)) else $error("NAND mismatch"); // R5
        if (op == 2'b10 && !inv_a && inv_b)
            AST_SUB_DIFF: assert ({carry, result} == diff_sum) else $error("difference mismatch"); // R6
        if (op == 2'b10 && !inv_a && !inv_b)
            AST_SIGNED_OVF: assert (overflow == ((opa[WIDTH-1] == opb[WIDTH-1]) &&
                                                 (result[WIDTH-1] != opa[WIDTH-1])))
                else $error("overflow mismatch"); // R7
        if (op == 2'b11 && !inv_a && !inv_b && opa == opb)
            AST_ZERO_EQUAL: assert (zero) else $error("zero flag missing"); // R8
    end
endmodule

bind alu16_sliced alu16_sliced_chk #(.WIDTH(WIDTH)) u_chk (
    .opa      (opa),
    .opb      (opb),
    .inv_a    (inv_a),
    .inv_b    (inv_b),
    .op       (op),
    .result   (result),
    .carry    (carry),
    .overflow (overflow),
    .zero     (zero)
);

// File: tb/sim_alu16_sliced.sv
`timescale 1ns/1ps
module sim_alu16_sliced;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0, opb = '0;
    logic        inv_a = 1'b0, inv_b = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] result;
    logic        carry, overflow, zero;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu16_sliced u0 (
        .opa(opa), .opb(opb), .inv_a(inv_a), .inv_b(inv_b), .op(op),
        .result(result), .carry(carry), .overflow(overflow), .zero(zero)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h ia=%0d ib=%0d op=%0d)",
                     tag, act, exp, opa, opb, inv_a, inv_b, op);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic ia, input logic ib, input logic [1:0] o);
        @(posedge clk);
        #1;
        opa = a; opb = b; inv_a = ia; inv_b = ib; op = o;
        @(negedge clk);
    endtask

    // behavioural reference computed with integers
    task automatic run_vec(input logic [15:0] a, input logic [15:0] b,
                           input logic ia, input logic ib, input logic [1:0] o);
        int ea, eb, s, exp_res, exp_ovf;
        string tag;
        apply(a, b, ia, ib, o);
        ea = ia ? (32'hFFFF & ~int'(a)) : int'(a);
        eb = ib ? (32'hFFFF & ~int'(b)) : int'(b);
        s  = ea + eb + int'(ib);
        case (o)
            2'b00: begin exp_res = ea & eb; tag = "R1"; end
            2'b01: begin exp_res = ea | eb; tag = "R2"; end
            2'b11: begin exp_res = ea ^ eb; tag = "R3"; end
            default: begin exp_res = s & 32'hFFFF; tag = "R4"; end
        endcase
        if (ia || ib) tag = {tag, "/R5"};
        check({tag, " result"}, int'(result), exp_res);
        exp_ovf = (((ea >> 15) & 1) == ((eb >> 15) & 1)) &&
                  (((s >> 15) & 1) != ((ea >> 15) & 1));
        check((o == 2'b10) ? "R4 carry" : "R9 carry", int'(carry), (s >> 16) & 1);
        check("R7 overflow", int'(overflow), exp_ovf);
        check("R8 zero", int'(zero), int'(exp_res == 0));
    endtask

    task automatic run_sub(input logic [15:0] a, input logic [15:0] b);
        apply(a, b, 1'b0, 1'b1, 2'b10);
        check("R6 difference", int'(result), (int'(a) - int'(b)) & 32'hFFFF);
        check("R6 borrow-free carry", int'(carry), int'(a >= b));
    endtask

    initial begin
        logic [15:0] corners [6] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h5A5A};
        logic [15:0] ra, rb;
        logic [15:0] keep_res;
        logic        keep_c;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 16; k++)
                    run_vec(corners[i], corners[j], k[3], k[2], k[1:0]);

        for (int n = 0; n < 2000; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            run_vec(ra, rb, 1'($urandom), 1'($urandom), 2'($urandom));
        end

        run_sub(16'h0005, 16'h0003);
        run_sub(16'h0003, 16'h0005);
        run_sub(16'h8000, 16'h0001);
        run_sub(16'h1234, 16'h1234);
        run_sub(16'h0000, 16'hFFFF);

        // R9: logic function ignores carry; carry still reports the adder chain
        apply(16'hFFFF, 16'h0001, 1'b0, 1'b0, 2'b00);
        check("R9 AND with full carry", int'(result), 32'h0001);
        check("R9 carry under AND", int'(carry), 1);
        keep_res = result; keep_c = carry;
        apply(16'h1357, 16'h2468, 1'b1, 1'b0, 2'b11);
        apply(16'hFFFF, 16'h0001, 1'b0, 1'b0, 2'b00);
        check("R9 repeat result", int'(result), int'(keep_res));
        check("R9 repeat carry", int'(carry), int'(keep_c));

        // R7 directed: 7FFF + 1 overflows, 8000 - 1 overflows
        apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, 2'b10);
        check("R7 pos overflow", int'(overflow), 1);
        apply(16'h8000, 16'h0001, 1'b0, 1'b1, 2'b10);
        check("R7 neg overflow", int'(overflow), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule